// File: doc/BRIEF.md
# Memory Bus Error Capture Register

This block records the first bus error reported to a memory controller and keeps it for software to inspect. An error event carries a word address, a read/write direction, the agent that caused it (CPU or DMA), and whether an ECC checker flagged it. The first event seen while the register is empty is stored. Any later event is dropped until software acknowledges the error by writing to the register. While an error is held, the interrupt output stays asserted.

Besides the raw register image, the block presents two decoded outputs. The first is a 2-bit classification of the error: CPU timeout, DMA overrun, ECC memory read, or ECC partial memory write. The second is a byte address ready for reporting. For ECC read errors, the ECC checker runs a few words behind the bus, so the stored word address is five words ahead of the word that failed. The block subtracts five inside the low 12 bits of the word address, wrapping within a 4K-word window, before it scales the result to a byte address.

Top module: `bus_err_capture`

## Requirements
- R1: During and after reset, `reg_rdata`, `irq`, `err_class` and `err_byte_addr` are all zero.
- R2: An event accepted while the register is empty is stored and appears on `reg_rdata` one cycle later. The field layout is: bit 31 valid, bit 30 agent (1 = CPU, 0 = DMA), bit 29 write (1 = write), bit 28 ECC error, bits 26:0 the word address as given. All other bits read as zero.
- R3: While valid is set and no register write occurs, new events are ignored and every field keeps the first error.
- R4: A pulse on `reg_wr` clears the whole register to zero and drops `irq` on the next cycle. The write strobe carries no data, so nothing written can change this.
- R5: When `reg_wr` and `ev_valid` occur in the same cycle, the clear and the capture happen together, and the new event is stored.
- R6: `irq` is high exactly while the valid bit (bit 31) of `reg_rdata` is set.
- R7: For a non-ECC error, `err_class` is 2'b00 (timeout) when the agent is the CPU and 2'b01 (overrun) when the agent is DMA, whatever the direction.
- R8: For an ECC error, `err_class` is 2'b10 (memory read) on a read and 2'b11 (partial memory write) on a write, whatever the agent.
- R9: For an ECC read error, the reporting word address is the stored address with 5 subtracted modulo 4096 from bits 11:0 only. Bits 26:12 stay unchanged.
- R10: `err_byte_addr` is the reporting word address shifted left by 2. For any error other than an ECC read, the reporting word address is the stored address unchanged.
- R11: While valid is clear, `err_class` and `err_byte_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Error event strobe, one cycle per event |
| ev_cpu | input | 1 | Event agent: 1 = CPU, 0 = DMA |
| ev_write | input | 1 | Event direction: 1 = write, 0 = read |
| ev_ecc | input | 1 | Event raised by the ECC checker |
| ev_waddr | input | 27 | Word address of the failing cycle |
| reg_wr | input | 1 | Register write strobe; clears the captured error |
| reg_rdata | output | 32 | Register read image |
| irq | output | 1 | Interrupt, high while an error is held |
| err_class | output | 2 | Decoded error class |
| err_byte_addr | output | 29 | Corrected byte address for reporting |

## Verification
The hardest situation to reach is a new error arriving in the very cycle that software clears the previous one. The bench gets there by holding a first error, then driving `reg_wr` and `ev_valid` on the same clock edge, and checking that the second error, not an empty register, is what remains. A second hard-to-reach case is the page wrap of the ECC read correction. It only shows up when the stored low bits are below five, so the stimulus places an ECC read at word offset 3 of a page. It then checks that the reported byte address falls near the top of the same page and does not borrow from the upper bits.

// File: rtl/bec_pkg.sv
package bec_pkg;

  typedef enum logic [1:0] {
    CLS_TIMEOUT = 2'b00,
    CLS_OVERRUN = 2'b01,
    CLS_ECC_RD  = 2'b10,
    CLS_ECC_WR  = 2'b11
  } err_cls_e;

  typedef struct packed {
    logic valid;
    logic cpu;
    logic write;
    logic ecc;
  } err_flags_t;

  localparam int RD_VALID_BIT = 31;
  localparam int RD_CPU_BIT   = 30;
  localparam int RD_WRITE_BIT = 29;
  localparam int RD_ECC_BIT   = 28;

endpackage

// File: rtl/bec_latch.sv
module bec_latch
  import bec_pkg::*;
#(
  parameter int ADDR_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic              ev_cpu,
  input  logic              ev_write,
  input  logic              ev_ecc,
  input  logic [ADDR_W-1:0] ev_waddr,
  input  logic              clr,
  output err_flags_t        q_flags,
  output logic [ADDR_W-1:0] q_waddr
);

  err_flags_t        d_flags;
  logic [ADDR_W-1:0] d_waddr;
  logic              load;
  logic              en;

  // capture when empty, or when the held error is being acknowledged
  always_comb begin
    load    = ev_valid && (!q_flags.valid || clr);
    en      = load || clr;
    d_flags = '0;
    d_waddr = '0;
    if (load) begin
      d_flags = '{valid: 1'b1, cpu: ev_cpu, write: ev_write, ecc: ev_ecc};
      d_waddr = ev_waddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_flags <= '0;
      q_waddr <= '0;
    end else if (en) begin
      q_flags <= d_flags;
      q_waddr <= d_waddr;
    end
  end

  // R3: a held error survives any event until acknowledged
  a_r3_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
    q_flags.valid && !clr |=> $stable(q_flags) && $stable(q_waddr));

  // R4: acknowledge without a new event empties the register
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !ev_valid |=> !q_flags.valid && q_waddr == '0);

  // R5: event coinciding with acknowledge is retained
  a_r5_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    clr && ev_valid |=> q_flags.valid && q_waddr == $past(ev_waddr));

endmodule

// File: rtl/bec_classify.sv
module bec_classify
  import bec_pkg::*;
(
  input  err_flags_t flags,
  output err_cls_e   cls
);

  always_comb begin
    if (!flags.valid)    cls = CLS_TIMEOUT;
    else if (flags.ecc)  cls = flags.write ? CLS_ECC_WR : CLS_ECC_RD;
    else                 cls = flags.cpu ? CLS_TIMEOUT : CLS_OVERRUN;
  end

endmodule

// File: rtl/bec_addr_fix.sv
module bec_addr_fix #(
  parameter int ADDR_W = 27,
  parameter int PAGE_W = 12,
  parameter int SKEW   = 5
) (
  input  logic              valid,
  input  logic              ecc,
  input  logic              write,
  input  logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W+1:0] byte_addr
);

  localparam logic [PAGE_W-1:0] SKEW_V = PAGE_W'(SKEW);

  logic [PAGE_W-1:0] low_back;
  logic [ADDR_W-1:0] adj;
  logic              rollback;

  always_comb begin
    rollback = ecc && !write;
    low_back = waddr[PAGE_W-1:0] - SKEW_V;
    adj      = waddr;
    if (rollback) adj[PAGE_W-1:0] = low_back;
    byte_addr = valid ? {adj, 2'b00} : '0;
  end

endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
  import bec_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int PAGE_W = 12,
  parameter int SKEW   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic              ev_cpu,
  input  logic              ev_write,
  input  logic              ev_ecc,
  input  logic [ADDR_W-1:0] ev_waddr,
  input  logic              reg_wr,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic [1:0]        err_class,
  output logic [ADDR_W+1:0] err_byte_addr
);

  localparam int BYTE_W = ADDR_W + 2;

  err_flags_t        flags;
  logic [ADDR_W-1:0] waddr;
  err_cls_e          cls;

  bec_latch #(.ADDR_W(ADDR_W)) latch_i (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_cpu(ev_cpu), .ev_write(ev_write),
    .ev_ecc(ev_ecc), .ev_waddr(ev_waddr), .clr(reg_wr),
    .q_flags(flags), .q_waddr(waddr)
  );

  bec_classify class_i (.flags(flags), .cls(cls));

  bec_addr_fix #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SKEW(SKEW)) fix_i (
    .valid(flags.valid), .ecc(flags.ecc), .write(flags.write),
    .waddr(waddr), .byte_addr(err_byte_addr)
  );

  always_comb begin
    reg_rdata               = '0;
    reg_rdata[ADDR_W-1:0]   = waddr;
    reg_rdata[RD_VALID_BIT] = flags.valid;
    reg_rdata[RD_CPU_BIT]   = flags.cpu;
    reg_rdata[RD_WRITE_BIT] = flags.write;
    reg_rdata[RD_ECC_BIT]   = flags.ecc;
  end

  assign irq       = flags.valid;
  assign err_class = cls;

  // R6: interrupt only rises after an event was offered
  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_valid));

  // R7: non-ECC class follows agent
  a_r7_nonecc_class: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !reg_rdata[RD_ECC_BIT] |-> err_class == {1'b0, !reg_rdata[RD_CPU_BIT]});

  // R8: ECC class follows direction
  a_r8_ecc_class: assert property (@(posedge clk) disable iff (!rst_n)
    irq && reg_rdata[RD_ECC_BIT] |-> err_class == {1'b1, reg_rdata[RD_WRITE_BIT]});

  // R9/R10: page bits never altered, byte alignment kept
  a_r9_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> err_byte_addr[BYTE_W-1:PAGE_W+2] == reg_rdata[ADDR_W-1:PAGE_W]
            && err_byte_addr[1:0] == 2'b00);

  // R11: decoded outputs quiet when empty
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> err_class == 2'b00 && err_byte_addr == '0);

endmodule

// File: tb/bus_err_capture_tb.sv
module bus_err_capture_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_valid, ev_cpu, ev_write, ev_ecc, reg_wr;
  logic [26:0] ev_waddr;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [1:0]  err_class;
  logic [28:0] err_byte_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  bus_err_capture dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_cpu(ev_cpu),
    .ev_write(ev_write), .ev_ecc(ev_ecc), .ev_waddr(ev_waddr),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .irq(irq),
    .err_class(err_class), .err_byte_addr(err_byte_addr)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input bit c, input bit w, input bit e, input logic [26:0] a);
    return 32'h8000_0000 | (32'(c) << 30) | (32'(w) << 29) | (32'(e) << 28) | 32'(a);
  endfunction

  function automatic logic [31:0] exp_byte(input bit w, input bit e, input logic [26:0] a);
    logic [31:0] x;
    x = 32'(a);
    if (e && !w) x = (x & ~32'hfff) | ((x - 32'd5) & 32'hfff);
    return x << 2;
  endfunction

  task automatic fire(input bit c, input bit w, input bit e, input logic [26:0] a, input bit with_clr);
    @(negedge clk);
    ev_valid = 1'b1; ev_cpu = c; ev_write = w; ev_ecc = e; ev_waddr = a; reg_wr = with_clr;
    @(negedge clk);
    ev_valid = 1'b0; reg_wr = 1'b0; ev_waddr = '0;
  endtask

  task automatic ack();
    @(negedge clk); reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic check_held(input string req, input bit c, input bit w, input bit e,
                            input logic [26:0] a, input logic [1:0] cls);
    chk({req, " rdata"}, reg_rdata, exp_rd(c, w, e, a));
    chk({req, " irq"}, 32'(irq), 32'd1);
    chk({req, " class"}, 32'(err_class), 32'(cls));
    chk({req, " byte"}, 32'(err_byte_addr), exp_byte(w, e, a));
  endtask

  task automatic check_empty(input string req);
    chk({req, " rdata"}, reg_rdata, 32'd0);
    chk({req, " irq"}, 32'(irq), 32'd0);
    chk({req, " class/byte"}, 32'(err_class) | 32'(err_byte_addr), 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ev_valid = 0; ev_cpu = 0; ev_write = 0; ev_ecc = 0; ev_waddr = '0; reg_wr = 0;
    repeat (2) @(negedge clk);
    check_empty("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_empty("R1 after reset");
  endtask

  task automatic t_cpu_timeout();
    fire(1, 0, 0, 27'h0123456, 0);
    check_held("R2 R6 R7 cpu timeout", 1, 0, 0, 27'h0123456, 2'b00);
  endtask

  task automatic t_drop_second();
    fire(0, 1, 1, 27'h0000007, 0);
    check_held("R3 second dropped", 1, 0, 0, 27'h0123456, 2'b00);
    ack();
    check_empty("R4 cleared");
  endtask

  task automatic t_dma_overrun();
    fire(0, 1, 0, 27'h0002000, 0);
    check_held("R7 R10 dma overrun", 0, 1, 0, 27'h0002000, 2'b01);
    ack();
  endtask

  task automatic t_ecc_read_wrap();
    fire(1, 0, 1, 27'h0012003, 0);
    check_held("R8 R9 ecc read wrap", 1, 0, 1, 27'h0012003, 2'b10);
    chk("R9 wrap literal", 32'(err_byte_addr), 32'h0004BFF8);
    ack();
  endtask

  task automatic t_ecc_read_plain();
    fire(0, 0, 1, 27'h4005678, 0);
    check_held("R9 ecc read dma", 0, 0, 1, 27'h4005678, 2'b10);
    chk("R9 plain literal", 32'(err_byte_addr), 32'h1001_59CC);
    ack();
  endtask

  task automatic t_ecc_write();
    fire(1, 1, 1, 27'h0000003, 0);
    check_held("R8 R10 ecc partial write", 1, 1, 1, 27'h0000003, 2'b11);
    chk("R10 no rollback", 32'(err_byte_addr), 32'h0000000C);
  endtask

  task automatic t_clear_and_capture();
    fire(0, 0, 0, 27'h7FFFFFF, 1);
    check_held("R5 same-cycle capture", 0, 0, 0, 27'h7FFFFFF, 2'b01);
    ack();
    check_empty("R4 R11 cleared again");
  endtask

  task automatic t_write_when_empty();
    ack();
    check_empty("R4 write while empty");
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cpu_timeout();
    t_drop_second();
    t_dma_overrun();
    t_ecc_read_wrap();
    t_ecc_read_plain();
    t_ecc_write();
    t_clear_and_capture();
    t_write_when_empty();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule